// File: doc/BRIEF.md
# Partial-Subblock Translation Buffer

This block is a small, fully associative address translation buffer. Each entry covers one aligned region of sixteen consecutive 4 KB virtual pages. An entry keeps a single physical region number and a single attribute field, and every page it maps uses both. A sixteen-bit presence vector in the entry records which pages of the region are mapped.

A lookup takes a virtual page number. The result appears on registered outputs one cycle after the request. On a hit the physical page is the stored region number with the low four bits of the virtual page appended.

A fill installs one page mapping. If an entry already holds the same virtual region, the fill must also match that entry's physical region and attribute field. In that case the fill only sets one presence bit. Otherwise the fill takes a new entry, chosen in round-robin order, and any stale copy of that page held elsewhere is removed. A single-cycle invalidate input empties the whole buffer.

Top module: `psb_tlb`

## Requirements
- R1: After reset or an invalidate-all pulse, every lookup misses, and the next allocation uses entry 0.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high. While `rsp_hit` is low, `rsp_ppn` and `rsp_attr` read zero.
- R3: A lookup that hits returns `{stored physical region, lk_vpn[3:0]}` on `rsp_ppn` and the stored attribute field on `rsp_attr`.
- R4: A lookup misses when the virtual region tag (`lk_vpn[19:4]`) matches an entry but that entry's presence bit for `lk_vpn[3:0]` is clear.
- R5: A fill merges into an entry when three conditions hold: the tag matches, `fill_ppn[19:4]` equals the stored region, and the attributes are equal. A merge sets only the presence bit, so the pages already in the entry keep translating unchanged.
- R6: A merge does not consume an entry and does not advance the replacement pointer.
- R7: A fill whose tag matches but whose physical region or attribute differs goes to a new entry. The other pages in the old entry still hit with their old translation.
- R8: A slot is never valid in two entries. Re-filling a present page with a different mapping makes later lookups return the new mapping.
- R9: New entries are allocated in round-robin order 0,1,...,7,0. The ninth allocation after an invalidate evicts the region that was allocated first.
- R10: A lookup in the same cycle as a fill sees the contents from before the fill.
- R11: An invalidate in the same cycle as a fill wins, and the fill is discarded.
- R12: A fill with `fill_ppn[3:0] != fill_vpn[3:0]` is not aligned and is dropped with no change to any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Clear every presence bit and reset the replacement pointer |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| fill_req | input | 1 | Install one page mapping |
| fill_vpn | input | 20 | Virtual page of the mapping |
| fill_ppn | input | 20 | Physical page of the mapping |
| fill_attr | input | 4 | Attribute field of the mapping |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 20 | Translated physical page |
| rsp_attr | output | 4 | Attributes of the hit page |

## Verification
A lookup result is due on the first clock edge after the request, and a fill or invalidate changes the contents on the edge where it is sampled. The bench drives every request on a falling edge and holds it for exactly one cycle. It reads the result on the next falling edge, after the one register stage has updated. A fill's effect is therefore checked only by a later lookup, one response cycle after that lookup. For the same-cycle cases, fill with lookup and fill with invalidate, the two requests share one cycle, and the bench checks the response from that cycle before it checks any later one.

// File: rtl/psb_pkg.sv
package psb_pkg;
  // Action a fill performs on one entry.
  typedef enum logic [1:0] {
    ENT_KEEP  = 2'd0,
    ENT_MERGE = 2'd1,
    ENT_ALLOC = 2'd2,
    ENT_DROP  = 2'd3
  } ent_act_e;
endpackage

// File: rtl/psb_entry.sv
module psb_entry
  import psb_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int REG_W  = 16,
  parameter int ATTR_W = 4,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [SUB_W-1:0]  lk_slot,
  input  logic [TAG_W-1:0]  fl_tag,
  input  logic [SUB_W-1:0]  fl_slot,
  input  logic [REG_W-1:0]  fl_region,
  input  logic [ATTR_W-1:0] fl_attr,
  input  ent_act_e          act,
  output logic              lk_hit,
  output logic [REG_W-1:0]  lk_region,
  output logic [ATTR_W-1:0] lk_attr,
  output logic              fl_tag_hit,
  output logic              fl_can_merge
);
  localparam int SLOTS = 1 << SUB_W;

  logic [TAG_W-1:0]  tag_q,    tag_d;
  logic [REG_W-1:0]  region_q, region_d;
  logic [ATTR_W-1:0] attr_q,   attr_d;
  logic [SLOTS-1:0]  vld_q,    vld_d;
  logic              meta_en, vld_en;
  logic [SLOTS-1:0]  fl_onehot;
  logic              any_vld;

  assign any_vld      = |vld_q;
  assign fl_onehot    = SLOTS'(1) << fl_slot;
  assign lk_hit       = (tag_q == lk_tag) && vld_q[lk_slot];
  assign lk_region    = region_q;
  assign lk_attr      = attr_q;
  assign fl_tag_hit   = any_vld && (tag_q == fl_tag);
  assign fl_can_merge = fl_tag_hit && (region_q == fl_region) && (attr_q == fl_attr);

  always_comb begin
    tag_d    = tag_q;
    region_d = region_q;
    attr_d   = attr_q;
    vld_d    = vld_q;
    meta_en  = 1'b0;
    vld_en   = 1'b0;
    if (inv_all) begin
      vld_d  = '0;
      vld_en = 1'b1;
    end else begin
      unique case (act)
        ENT_ALLOC: begin
          tag_d    = fl_tag;
          region_d = fl_region;
          attr_d   = fl_attr;
          vld_d    = fl_onehot;
          meta_en  = 1'b1;
          vld_en   = 1'b1;
        end
        ENT_MERGE: begin
          vld_d  = vld_q | fl_onehot;
          vld_en = 1'b1;
        end
        ENT_DROP: begin
          vld_d  = vld_q & ~fl_onehot;
          vld_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q    <= '0;
      region_q <= '0;
      attr_q   <= '0;
    end else if (meta_en) begin
      tag_q    <= tag_d;
      region_q <= region_d;
      attr_q   <= attr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (vld_en) vld_q <= vld_d;
  end

  // R5: a merge leaves the shared physical region and attributes untouched
  assert_merge_keeps_meta_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ENT_MERGE && !inv_all) |=> ($stable(region_q) && $stable(attr_q)));

  // R7: a freshly allocated entry holds exactly one page
  assert_alloc_single_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ENT_ALLOC && !inv_all) |=> ($countones(vld_q) == 1));
endmodule

// File: rtl/psb_victim.sv
module psb_victim #(
  parameter int N_ENT = 8,
  parameter int PTR_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             alloc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = inv_all || alloc;
    if (inv_all)                          ptr_d = '0;
    else if (ptr_q == PTR_W'(N_ENT - 1))  ptr_d = '0;
    else                                  ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R6: the pointer only moves on an allocation or an invalidate
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && !inv_all) |=> $stable(ptr_q));
endmodule

// File: rtl/psb_fill_ctl.sv
module psb_fill_ctl
  import psb_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int PTR_W = $clog2(N_ENT)
) (
  input  logic             fill_ok,
  input  logic [N_ENT-1:0] tag_hit,
  input  logic [N_ENT-1:0] can_merge,
  input  logic [PTR_W-1:0] victim,
  output ent_act_e         act [N_ENT],
  output logic             alloc
);
  logic [N_ENT-1:0] merge_sel;
  logic             any_merge;

  // Lowest-index merge candidate (at most one exists in practice).
  always_comb begin
    merge_sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (can_merge[i]) merge_sel = N_ENT'(1) << i;
    end
  end

  assign any_merge = |can_merge;
  assign alloc     = fill_ok && !any_merge;

  for (genvar g = 0; g < N_ENT; g++) begin : g_act
    always_comb begin
      act[g] = ENT_KEEP;
      if (fill_ok) begin
        if (alloc && victim == PTR_W'(g)) act[g] = ENT_ALLOC;
        else if (merge_sel[g])            act[g] = ENT_MERGE;
        else if (tag_hit[g])              act[g] = ENT_DROP;
      end
    end
  end
endmodule

// File: rtl/psb_tlb.sv
module psb_tlb
  import psb_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 4,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              fill_req,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [ATTR_W-1:0] rsp_attr
);
  localparam int TAG_W = VPN_W - SUB_W;
  localparam int REG_W = PPN_W - SUB_W;
  localparam int PTR_W = $clog2(N_ENT);

  logic [N_ENT-1:0]  hit_vec, tag_hit_vec, merge_vec;
  logic [REG_W-1:0]  ent_region [N_ENT];
  logic [ATTR_W-1:0] ent_attr   [N_ENT];
  ent_act_e          act        [N_ENT];
  logic [PTR_W-1:0]  victim;
  logic              alloc, fill_ok;

  assign fill_ok = fill_req && !inv_all &&
                   (fill_ppn[SUB_W-1:0] == fill_vpn[SUB_W-1:0]);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    psb_entry #(
      .TAG_W(TAG_W), .REG_W(REG_W), .ATTR_W(ATTR_W), .SUB_W(SUB_W)
    ) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .inv_all      (inv_all),
      .lk_tag       (lk_vpn[VPN_W-1:SUB_W]),
      .lk_slot      (lk_vpn[SUB_W-1:0]),
      .fl_tag       (fill_vpn[VPN_W-1:SUB_W]),
      .fl_slot      (fill_vpn[SUB_W-1:0]),
      .fl_region    (fill_ppn[PPN_W-1:SUB_W]),
      .fl_attr      (fill_attr),
      .act          (act[g]),
      .lk_hit       (hit_vec[g]),
      .lk_region    (ent_region[g]),
      .lk_attr      (ent_attr[g]),
      .fl_tag_hit   (tag_hit_vec[g]),
      .fl_can_merge (merge_vec[g])
    );
  end

  psb_fill_ctl #(.N_ENT(N_ENT), .PTR_W(PTR_W)) u_ctl (
    .fill_ok   (fill_ok),
    .tag_hit   (tag_hit_vec),
    .can_merge (merge_vec),
    .victim    (victim),
    .act       (act),
    .alloc     (alloc)
  );

  psb_victim #(.N_ENT(N_ENT), .PTR_W(PTR_W)) u_vic (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_all (inv_all),
    .alloc   (alloc),
    .ptr     (victim)
  );

  // Lookup result selection (AND-OR over one-hot hits).
  logic              sel_hit;
  logic [REG_W-1:0]  sel_region;
  logic [ATTR_W-1:0] sel_attr;

  always_comb begin
    sel_region = '0;
    sel_attr   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      sel_region = sel_region | (ent_region[i] & {REG_W{hit_vec[i]}});
      sel_attr   = sel_attr   | (ent_attr[i]   & {ATTR_W{hit_vec[i]}});
    end
    sel_hit = |hit_vec;
  end

  logic              rv_q, rh_q, rh_d;
  logic [PPN_W-1:0]  rp_q, rp_d;
  logic [ATTR_W-1:0] ra_q, ra_d;
  logic              rsp_en;

  always_comb begin
    rsp_en = lk_req || rv_q;
    rh_d   = lk_req && sel_hit;
    rp_d   = rh_d ? {sel_region, lk_vpn[SUB_W-1:0]} : '0;
    ra_d   = rh_d ? sel_attr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= lk_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q <= 1'b0;
      rp_q <= '0;
      ra_q <= '0;
    end else if (rsp_en) begin
      rh_q <= rh_d;
      rp_q <= rp_d;
      ra_q <= ra_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_ppn   = rp_q;
  assign rsp_attr  = ra_q;

  // R8: a page is present in at most one entry
  assert_single_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2: a hit is only reported alongside a valid response
  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R1: right after an invalidate, a lookup cannot hit
  assert_inv_then_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all ##1 lk_req) |=> !rsp_hit);

  // R12: a misaligned fill never allocates
  assert_misaligned_no_alloc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_ppn[SUB_W-1:0] != fill_vpn[SUB_W-1:0]) |-> !alloc);
endmodule

// File: tb/sim_psb_tlb.sv
module sim_psb_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inv_all, lk_req, fill_req;
  logic [19:0] lk_vpn, fill_vpn, fill_ppn;
  logic [3:0]  fill_attr;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_ppn;
  logic [3:0]  rsp_attr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  psb_tlb u0 (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_req(lk_req), .lk_vpn(lk_vpn),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_attr(rsp_attr)
  );

  localparam logic [1:0] OP_FILL = 2'd0, OP_LOOK = 2'd1, OP_INV = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [3:0]  attr;
    logic        hit;
    logic [19:0] eppn;
    logic [3:0]  eattr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{OP_FILL, 20'h12343, 20'hABCD3, 4'h5, 1'b0, 20'h0,     4'h0, 8'd3},
    '{OP_LOOK, 20'h12343, 20'h0,     4'h0, 1'b1, 20'hABCD3, 4'h5, 8'd3},
    '{OP_LOOK, 20'h12344, 20'h0,     4'h0, 1'b0, 20'h0,     4'h0, 8'd4},
    '{OP_FILL, 20'h12344, 20'hABCD4, 4'h5, 1'b0, 20'h0,     4'h0, 8'd5},
    '{OP_LOOK, 20'h12344, 20'h0,     4'h0, 1'b1, 20'hABCD4, 4'h5, 8'd5},
    '{OP_LOOK, 20'h12343, 20'h0,     4'h0, 1'b1, 20'hABCD3, 4'h5, 8'd5},
    '{OP_FILL, 20'h12345, 20'h55555, 4'h5, 1'b0, 20'h0,     4'h0, 8'd7},
    '{OP_LOOK, 20'h12345, 20'h0,     4'h0, 1'b1, 20'h55555, 4'h5, 8'd7},
    '{OP_LOOK, 20'h12344, 20'h0,     4'h0, 1'b1, 20'hABCD4, 4'h5, 8'd7},
    '{OP_FILL, 20'h12346, 20'hABCD6, 4'h9, 1'b0, 20'h0,     4'h0, 8'd7},
    '{OP_LOOK, 20'h12346, 20'h0,     4'h0, 1'b1, 20'hABCD6, 4'h9, 8'd7},
    '{OP_FILL, 20'h12343, 20'h77773, 4'h2, 1'b0, 20'h0,     4'h0, 8'd8},
    '{OP_LOOK, 20'h12343, 20'h0,     4'h0, 1'b1, 20'h77773, 4'h2, 8'd8},
    '{OP_FILL, 20'h12347, 20'hABCD8, 4'h5, 1'b0, 20'h0,     4'h0, 8'd12},
    '{OP_LOOK, 20'h12347, 20'h0,     4'h0, 1'b0, 20'h0,     4'h0, 8'd12},
    '{OP_LOOK, 20'h12344, 20'h0,     4'h0, 1'b1, 20'hABCD4, 4'h5, 8'd12},
    '{OP_INV,  20'h0,     20'h0,     4'h0, 1'b0, 20'h0,     4'h0, 8'd1},
    '{OP_LOOK, 20'h12344, 20'h0,     4'h0, 1'b0, 20'h0,     4'h0, 8'd1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] exp_v,
                     input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp_v);
    end
  endtask

  task automatic check_rsp(input logic eh, input logic [19:0] ep, input logic [3:0] ea, input int rq);
    chk(rsp_valid === 1'b1, rq, 32'(rsp_valid), 32'd1, "rsp_valid");
    chk(rsp_hit === eh, rq, 32'(rsp_hit), 32'(eh), "rsp_hit");
    chk(rsp_ppn === ep, rq, 32'(rsp_ppn), 32'(ep), "rsp_ppn");
    chk(rsp_attr === ea, rq, 32'(rsp_attr), 32'(ea), "rsp_attr");
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] a);
    fill_req = 1'b1; fill_vpn = v; fill_ppn = p; fill_attr = a;
    tick();
    fill_req = 1'b0;
  endtask

  task automatic do_look(input logic [19:0] v, input logic eh, input logic [19:0] ep,
                         input logic [3:0] ea, input int rq);
    lk_req = 1'b1; lk_vpn = v;
    tick();
    lk_req = 1'b0;
    check_rsp(eh, ep, ea, rq);
  endtask

  task automatic do_inv();
    inv_all = 1'b1;
    tick();
    inv_all = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; inv_all = 1'b0; lk_req = 1'b0; fill_req = 1'b0;
    lk_vpn = '0; fill_vpn = '0; fill_ppn = '0; fill_attr = '0;
    repeat (3) @(negedge clk);
    // R2: reset state of the response outputs
    chk(rsp_valid === 1'b0, 2, 32'(rsp_valid), 32'd0, "reset rsp_valid");
    chk(rsp_hit === 1'b0, 2, 32'(rsp_hit), 32'd0, "reset rsp_hit");
    rst_n = 1'b1;
    tick();
    // R1: empty after reset
    do_look(20'h12343, 1'b0, 20'h0, 4'h0, 1);

    // Vector table walk (R3 R4 R5 R7 R8 R12 R1)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_FILL: do_fill(VEC[i].vpn, VEC[i].ppn, VEC[i].attr);
        OP_LOOK: do_look(VEC[i].vpn, VEC[i].hit, VEC[i].eppn, VEC[i].eattr, int'(VEC[i].req));
        default: do_inv();
      endcase
    end

    // R2: idle cycle drops rsp_valid and zeroes the payload
    tick();
    chk(rsp_valid === 1'b0, 2, 32'(rsp_valid), 32'd0, "idle rsp_valid");
    chk(rsp_ppn === 20'h0, 2, 32'(rsp_ppn), 32'd0, "idle rsp_ppn");

    // R6 R9: merge must not advance the pointer; ninth allocation evicts entry 0
    do_inv();
    do_fill(20'h00010, 20'h01010, 4'h1);
    do_fill(20'h00011, 20'h01011, 4'h1);   // merge
    for (int k = 2; k <= 8; k++)
      do_fill({16'(k), 4'h0}, {16'(k + 16'h100), 4'h0}, 4'h1);
    do_look(20'h00011, 1'b1, 20'h01011, 4'h1, 6);
    do_fill(20'h00090, 20'h01090, 4'h1);   // ninth allocation
    do_look(20'h00011, 1'b0, 20'h0, 4'h0, 9);
    do_look(20'h00010, 1'b0, 20'h0, 4'h0, 9);
    do_look(20'h00020, 1'b1, 20'h01020, 4'h1, 6);
    do_look(20'h00080, 1'b1, 20'h01080, 4'h1, 9);
    do_look(20'h00090, 1'b1, 20'h01090, 4'h1, 9);

    // R1: invalidate resets the pointer; next allocation goes to entry 0,
    // so eight more allocations leave the first of them intact
    do_inv();
    for (int k = 1; k <= 8; k++)
      do_fill({16'(k + 16'h40), 4'h3}, {16'(k + 16'h200), 4'h3}, 4'h6);
    do_look(20'h00413, 1'b1, 20'h02013, 4'h6, 1);

    // R10: lookup in the fill cycle sees the old contents
    do_inv();
    lk_req = 1'b1; lk_vpn = 20'h33337;
    fill_req = 1'b1; fill_vpn = 20'h33337; fill_ppn = 20'h44447; fill_attr = 4'hA;
    tick();
    lk_req = 1'b0; fill_req = 1'b0;
    check_rsp(1'b0, 20'h0, 4'h0, 10);
    do_look(20'h33337, 1'b1, 20'h44447, 4'hA, 10);

    // R11: invalidate beats a simultaneous fill
    inv_all = 1'b1;
    fill_req = 1'b1; fill_vpn = 20'h66661; fill_ppn = 20'h88881; fill_attr = 4'h3;
    tick();
    inv_all = 1'b0; fill_req = 1'b0;
    do_look(20'h66661, 1'b0, 20'h0, 4'h0, 11);
    do_look(20'h33337, 1'b0, 20'h0, 4'h0, 11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule